// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This unit evaluates one of four integer operations on a pair of 32-bit operands and registers the outcome. A two-bit opcode picks the operation: a signed ordering compare, an unsigned ordering compare, generation of the carry-out of an add with carry-in, or a search for the first byte lane in which both operands hold the same byte.

Both compares return the difference of the second operand minus the first. When the two operands have different top bits, the top bit of that difference is replaced so that it gives the ordering. The byte search scans from the most significant lane downward and reports a 1-based lane number, or zero when no lane matches.

Each operation is issued with a one-cycle start pulse. The result register and a valid strobe update on the next clock edge. Between starts the result word holds its value.

Top module: `intcmp_match_unit`

## Requirements
- R1: For opcode 00 (signed compare) and opcode 01 (unsigned compare), when bit 31 of opa_i equals bit 31 of opb_i, the result is opb_i + ~opa_i + 1 modulo 2^32.
- R2: For opcode 00, when bit 31 of the operands differ, result bits 30:0 are those of the difference and result bit 31 equals bit 31 of opb_i.
- R3: For opcode 01, when bit 31 of the operands differ, result bits 30:0 are those of the difference and result bit 31 equals bit 31 of opa_i.
- R4: For opcode 10 (carry), result bit 0 is 1 when opb_i is all ones and carry_i is 1, or when opa_i + opb_i + carry_i exceeds 2^32 - 1; otherwise it is 0.
- R5: For opcode 10, result bits 31:1 are zero.
- R6: For opcode 11 (byte find), lanes are examined in the order bits 31:24, 23:16, 15:8, 7:0. The result is 1, 2, 3 or 4 for the first lane in that order where both operands hold equal bytes.
- R7: For opcode 11, the result is 0 when no lane matches.
- R8: result_o takes the value of an operation, and valid_o is 1, exactly one clock edge after the edge that samples start_i high. valid_o is 0 after any edge that samples start_i low.
- R9: result_o keeps its value across every edge that samples start_i low.
- R10: A synchronous active-high rst clears result_o and valid_o on the next edge, and it overrides start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to evaluate the operation |
| opcode_i | input | 2 | 00 signed cmp, 01 unsigned cmp, 10 carry, 11 byte find |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| carry_i | input | 1 | Carry-in for the carry operation |
| result_o | output | 32 | Registered result word |
| valid_o | output | 1 | High for one cycle when result_o holds a new result |

## Verification
Every result is due on the first clock edge after the edge that captures start_i. The bench changes inputs on the falling edge, holds start high for one cycle, and reads result_o and valid_o at the next falling edge, which is half a period after the edge that loaded them. It then reads once more a cycle later, with start low, to confirm that valid_o has dropped and result_o has not moved. Reset is checked the same way, one edge after it is applied, including the case where start is high at the same time.

// File: rtl/icu_pkg.sv
package icu_pkg;
    typedef enum logic [1:0] {
        OP_SCMP  = 2'b00,
        OP_UCMP  = 2'b01,
        OP_CARRY = 2'b10,
        OP_FIND  = 2'b11
    } icu_op_e;
endpackage

// File: rtl/icu_compare.sv
module icu_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] signed_res,
    output logic [DATA_W-1:0] unsigned_res
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] diff;
    logic              sign_mismatch;

    always_comb begin
        diff          = opb + ~opa + DATA_W'(1);
        sign_mismatch = opa[MSB] ^ opb[MSB];
        signed_res    = diff;
        unsigned_res  = diff;
        if (sign_mismatch) begin
            signed_res[MSB]   = opb[MSB];
            unsigned_res[MSB] = opa[MSB];
        end
    end
endmodule

// File: rtl/icu_carry.sv
module icu_carry #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cin,
    output logic              cout
);
    logic [DATA_W:0] wide_sum;
    logic            b_saturated;

    always_comb begin
        wide_sum    = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
        b_saturated = (&opb) & cin;
        cout        = b_saturated | wide_sum[DATA_W];
    end
endmodule

// File: rtl/icu_bytefind.sv
module icu_bytefind #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W,
    localparam int IDX_W = $clog2(LANES + 1)
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [IDX_W-1:0]  lane_num
);
    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (opa[g*LANE_W +: LANE_W] == opb[g*LANE_W +: LANE_W]);
    end

    // Scan from low lane upward; the last hit (most significant) wins.
    always_comb begin
        lane_num = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_eq[i]) begin
                lane_num = IDX_W'(LANES - i);
            end
        end
    end
endmodule

// File: rtl/intcmp_match_unit.sv
module intcmp_match_unit
    import icu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W,
    localparam int IDX_W = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        opcode_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              valid;
    } unit_state_t;

    unit_state_t state_d, state_q;

    logic [DATA_W-1:0] scmp_res, ucmp_res;
    logic              carry_out;
    logic [IDX_W-1:0]  find_idx;

    icu_compare #(.DATA_W(DATA_W)) cmp_i (
        .opa          (opa_i),
        .opb          (opb_i),
        .signed_res   (scmp_res),
        .unsigned_res (ucmp_res)
    );

    icu_carry #(.DATA_W(DATA_W)) cry_i (
        .opa  (opa_i),
        .opb  (opb_i),
        .cin  (carry_i),
        .cout (carry_out)
    );

    icu_bytefind #(.DATA_W(DATA_W), .LANE_W(LANE_W)) fnd_i (
        .opa      (opa_i),
        .opb      (opb_i),
        .lane_num (find_idx)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        if (start_i) begin
            state_d.valid = 1'b1;
            unique case (icu_op_e'(opcode_i))
                OP_SCMP:  state_d.result = scmp_res;
                OP_UCMP:  state_d.result = ucmp_res;
                OP_CARRY: state_d.result = {{(DATA_W-1){1'b0}}, carry_out};
                OP_FIND:  state_d.result = {{(DATA_W-IDX_W){1'b0}}, find_idx};
                default:  state_d.result = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign valid_o  = state_q.valid;
endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [1:0]        opcode_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic              carry_i,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o
);
    localparam int MSB = DATA_W - 1;

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !valid_o));

    a_r8_valid_after_start: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);

    a_r8_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(result_o));

    a_r1_same_sign_diff: assert property (@(posedge clk) disable iff (rst)
        (start_i && !opcode_i[1] && (opa_i[MSB] == opb_i[MSB]))
        |=> result_o == $past(opb_i - opa_i));

    a_r2_signed_order_bit: assert property (@(posedge clk) disable iff (rst)
        (start_i && opcode_i == 2'b00 && (opa_i[MSB] != opb_i[MSB]))
        |=> result_o[MSB] == $past(opb_i[MSB]));

    a_r3_unsigned_order_bit: assert property (@(posedge clk) disable iff (rst)
        (start_i && opcode_i == 2'b01 && (opa_i[MSB] != opb_i[MSB]))
        |=> result_o[MSB] == $past(opa_i[MSB]));

    a_r4_saturated_carry: assert property (@(posedge clk) disable iff (rst)
        (start_i && opcode_i == 2'b10 && (&opb_i) && carry_i)
        |=> result_o[0]);

    a_r5_carry_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (start_i && opcode_i == 2'b10) |=> result_o[DATA_W-1:1] == '0);

    a_r6_find_range: assert property (@(posedge clk) disable iff (rst)
        (start_i && opcode_i == 2'b11) |=> result_o <= DATA_W'(DATA_W / 8));

    a_r6_top_lane_first: assert property (@(posedge clk) disable iff (rst)
        (start_i && opcode_i == 2'b11 && opa_i[MSB -: 8] == opb_i[MSB -: 8])
        |=> result_o == DATA_W'(1));
endmodule

bind intcmp_match_unit icu_checker #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/intcmp_match_unit_tb_top.sv
`timescale 1ns/1ps
module intcmp_match_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [1:0]  opcode_i;
    logic [31:0] opa_i, opb_i;
    logic        carry_i;
    logic [31:0] result_o;
    logic        valid_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    intcmp_match_unit dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
        .opa_i(opa_i), .opb_i(opb_i), .carry_i(carry_i),
        .result_o(result_o), .valid_o(valid_o)
    );

    function automatic logic [31:0] expect_val(logic [1:0] op, logic [31:0] a,
                                               logic [31:0] b, logic c);
        logic [31:0] t;
        logic [32:0] s;
        t = b - a;
        case (op)
            2'b00: if (a[31] != b[31]) t[31] = b[31];
            2'b01: if (a[31] != b[31]) t[31] = a[31];
            2'b10: begin
                s = 33'(a) + 33'(b) + 33'(c);
                t = {31'd0, ((b == 32'hFFFF_FFFF) && c) || s[32]};
            end
            default: begin
                t = 32'd0;
                if (a[7:0] == b[7:0])     t = 32'd4;
                if (a[15:8] == b[15:8])   t = 32'd3;
                if (a[23:16] == b[23:16]) t = 32'd2;
                if (a[31:24] == b[31:24]) t = 32'd1;
            end
        endcase
        return t;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation; check result and valid one edge later, then idle behaviour.
    task automatic run_op(string req, logic [1:0] op, logic [31:0] a,
                          logic [31:0] b, logic c);
        logic [31:0] exp;
        exp = expect_val(op, a, b, c);
        @(negedge clk);
        opcode_i = op; opa_i = a; opb_i = b; carry_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        opa_i = ~a; opb_i = a;
        check({req, " result"}, result_o, exp);
        check("R8 valid", 32'(valid_o), 32'd1);
        @(negedge clk);
        check("R8 valid drops", 32'(valid_o), 32'd0);
        check("R9 hold", result_o, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1; start_i = 1'b0; opcode_i = 2'b00;
        opa_i = '0; opb_i = '0; carry_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 result", result_o, 32'd0);
        check("R10 valid", 32'(valid_o), 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_reset_over_start();
        run_op("R1", 2'b00, 32'd3, 32'd10, 1'b0);
        @(negedge clk);
        rst = 1'b1; start_i = 1'b1; opcode_i = 2'b10;
        opa_i = 32'hFFFF_FFFF; opb_i = 32'd1;
        @(negedge clk);
        rst = 1'b0; start_i = 1'b0;
        check("R10 result with start", result_o, 32'd0);
        check("R10 valid with start", 32'(valid_o), 32'd0);
    endtask

    task automatic t_compare();
        run_op("R1", 2'b00, 32'd5, 32'd12, 1'b0);
        run_op("R1", 2'b00, 32'd12, 32'd5, 1'b0);
        run_op("R1", 2'b01, 32'h8000_0010, 32'h8000_0001, 1'b1);
        run_op("R1", 2'b01, 32'd7, 32'd7, 1'b0);
        run_op("R2", 2'b00, 32'd1, 32'h8000_0000, 1'b0);
        run_op("R2", 2'b00, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0);
        run_op("R3", 2'b01, 32'd1, 32'h8000_0000, 1'b0);
        run_op("R3", 2'b01, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0);
    endtask

    task automatic t_carry();
        run_op("R4", 2'b10, 32'd0, 32'hFFFF_FFFF, 1'b1);
        run_op("R4", 2'b10, 32'd0, 32'hFFFF_FFFF, 1'b0);
        run_op("R4", 2'b10, 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_op("R4", 2'b10, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
        run_op("R5", 2'b10, 32'h1234_5678, 32'h0000_0001, 1'b1);
    endtask

    task automatic t_bytefind();
        run_op("R6", 2'b11, 32'hAA11_2233, 32'hAA99_8877, 1'b0);
        run_op("R6", 2'b11, 32'h00BB_2233, 32'h01BB_8833, 1'b0);
        run_op("R6", 2'b11, 32'h0102_CC04, 32'hF1F2_CCF4, 1'b0);
        run_op("R6", 2'b11, 32'h0102_03DD, 32'hF1F2_F3DD, 1'b0);
        run_op("R7", 2'b11, 32'h0102_0304, 32'h1122_3344, 1'b0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 200; i++) begin
            logic [1:0]  op;
            logic [31:0] a, b;
            op = 2'($urandom_range(0, 3));
            a  = $urandom;
            b  = (i % 3 == 0) ? (a ^ (32'hFF << (8 * (i % 4)))) : $urandom;
            run_op("R1 R4 R6 random", op, a, b, 1'($urandom_range(0, 1)));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_compare();
        t_carry();
        t_bytefind();
        t_reset_over_start();
        t_random();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule